// File: doc/BRIEF.md
# GPIO Port Register Bank with Masked Pin Writes

This block holds the control state for a group of 16-pin GPIO ports and drives it onto the pad side. Each port owns a 64-byte window on a 32-bit register bus. Port p starts at byte address p × 0x40. Inside a window, software sets the output value, the output enable, the input enable, the pin function, the pull bias, the drive level and the slew rate of every pin, and it reads back the synchronized pad input. A flat pin number i belongs to port i / 16, at bit i % 16. The same mapping places each pin's fields on the flat pad-side vectors.

Four of the per-pin registers take a masked write. Bits 31:16 of the written word choose which of bits 15:0 are applied, so one pin changes without disturbing the others and without a read first. Pull and drive pack two bits per pin and are plain registers, so every write to them replaces the whole word. Port index 22 is special. It carries only drive and slew registers, and these sit at 0x590 and 0x594 instead of at the regular stride offsets.

The read path has one cycle of latency. `bus_rdata` shows the register addressed in the previous cycle.

Top module: `pb_bank`

## Requirements
- R1: After reset, output data, output enable, input enable, slew, drive and function registers read 0. Every pull field reads code 1, so a pull word reads 0x55555555 and every pad pull output is 2'b01.
- R2: Output data (offset 0x00), output enable (0x04), input enable (0x08) and slew (0x2C) are masked. On a write, pin n takes bit n only if bit n+16 is 1. Otherwise pin n keeps its value.
- R3: A read of a masked register returns the per-pin values in bits 15:0 and zero in bits 31:16.
- R4: Pull (0x24) and drive (0x28) hold 2 bits per pin, at bits 2n+1:2n. A write replaces the whole word. Pull code 0 selects pull-down, 1 selects no bias and 2 selects pull-up. Drive code 0 is the weakest and 3 the strongest.
- R5: The 3-bit function of pin k sits in 4-bit slots. Pins 0–7 are at 0x10, bits 4k+2:4k. Pins 8–15 are at 0x14, bits 4(k−8)+2:4(k−8). The top bit of each slot reads 0. A write replaces all eight functions in that word.
- R6: Offset 0x20 returns each port's pad inputs after a two-flop synchronizer. The register reflects a new pad value two clock edges after the change, and writes to it have no effect.
- R7: Port p's registers decode at p × 0x40. A write to one port leaves every other port's registers unchanged.
- R8: On port 22, drive sits at 0x590 (full replace) and slew sits at 0x594 (masked). All other offsets of that port read 0 and ignore writes, and its GPIO pad outputs stay at their reset values.
- R9: Unmapped offsets and ports at or above the port count read 0, and writing them changes no state.
- R10: After a write, the pad outputs of pin i (flat bits i, 2i+1:2i or 3i+2:3i) show the new value from the clock edge that takes the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address for read and write |
| bus_wr | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the address of the previous cycle |
| pad_in | input | NUM_PORTS*16 | Raw pad inputs, asynchronous |
| pad_out | output | NUM_PORTS*16 | Output value per pin |
| pad_oe | output | NUM_PORTS*16 | Output enable per pin |
| pad_ie | output | NUM_PORTS*16 | Input enable per pin |
| pad_pull | output | NUM_PORTS*32 | Pull code, 2 bits per pin |
| pad_drv | output | NUM_PORTS*32 | Drive code, 2 bits per pin |
| pad_slew | output | NUM_PORTS*16 | Slew select per pin |
| pad_func | output | NUM_PORTS*48 | Function select, 3 bits per pin |

## Verification
The hardest case to reach from the ports is the synchronizer latency on the input register. A bus read can only catch the old value if it is issued the cycle after a pad change. The stimulus changes a pad, reads back on the very next cycle to get the stale word, and then reads again to get the new one. The dedicated port needs a similar targeted sequence. The bench writes the regular drive offset of port 22 and the GPIO output word of that port, then checks that its relocated drive word and its pad outputs did not move.

// File: rtl/pb_pkg.sv
package pb_pkg;

    localparam int PINS_PER_PORT = 16;
    localparam int WORD_W        = 32;
    localparam int FUNC_W        = 3;
    localparam int FUNC_SLOT     = 4;
    localparam int WIN_SHIFT     = 6;
    localparam int FUNC_PER_WORD = WORD_W / FUNC_SLOT;

    typedef enum logic [3:0] {
        RK_NONE,
        RK_DOUT,
        RK_OEN,
        RK_IEN,
        RK_FLO,
        RK_FHI,
        RK_DIN,
        RK_PULL,
        RK_DRV,
        RK_SLEW
    } reg_kind_e;

    // Bits 31:16 select which of bits 15:0 are applied.
    function automatic logic [PINS_PER_PORT-1:0] mask_merge(
        input logic [PINS_PER_PORT-1:0] cur,
        input logic [WORD_W-1:0]        w
    );
        logic [PINS_PER_PORT-1:0] sel;
        sel = w[WORD_W-1:PINS_PER_PORT];
        return (cur & ~sel) | (w[PINS_PER_PORT-1:0] & sel);
    endfunction

    function automatic logic is_masked(input reg_kind_e k);
        return (k == RK_DOUT) || (k == RK_OEN) || (k == RK_IEN) || (k == RK_SLEW);
    endfunction

endpackage

// File: rtl/pb_decode.sv
module pb_decode
    import pb_pkg::*;
#(
    parameter int NUM_PORTS = 23,
    parameter int DED_PORT  = 22,
    parameter int ADDR_W    = 12,
    localparam int PIDX_W   = ADDR_W - WIN_SHIFT
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [PIDX_W-1:0] port_idx,
    output reg_kind_e         kind,
    output logic              hit
);

    localparam logic [PIDX_W-1:0] LAST_PORT = PIDX_W'(NUM_PORTS - 1);
    localparam logic [PIDX_W-1:0] DED_IDX   = PIDX_W'(DED_PORT);

    logic [3:0] word_off;
    logic       unused_lsb;

    assign port_idx   = addr[ADDR_W-1:WIN_SHIFT];
    assign word_off   = addr[WIN_SHIFT-1:2];
    assign unused_lsb = ^addr[1:0];
    assign hit        = (port_idx <= LAST_PORT);

    always_comb begin
        kind = RK_NONE;
        if (hit) begin
            if (port_idx == DED_IDX) begin
                unique case (word_off)
                    4'h4:    kind = RK_DRV;
                    4'h5:    kind = RK_SLEW;
                    default: kind = RK_NONE;
                endcase
            end else begin
                unique case (word_off)
                    4'h0:    kind = RK_DOUT;
                    4'h1:    kind = RK_OEN;
                    4'h2:    kind = RK_IEN;
                    4'h4:    kind = RK_FLO;
                    4'h5:    kind = RK_FHI;
                    4'h8:    kind = RK_DIN;
                    4'h9:    kind = RK_PULL;
                    4'hA:    kind = RK_DRV;
                    4'hB:    kind = RK_SLEW;
                    default: kind = RK_NONE;
                endcase
            end
        end
    end

endmodule

// File: rtl/pb_sync.sv
module pb_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d;
            sync_q <= meta_q;
        end
    end

    assign q = sync_q;

    logic [1:0] age_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              age_q <= 2'd0;
        else if (age_q != 2'd2)  age_q <= age_q + 2'd1;
    end

    p_two_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd2) |-> (q == $past(d, 2)));

endmodule

// File: rtl/pb_port.sv
module pb_port
    import pb_pkg::*;
#(
    parameter bit IS_DED = 1'b0,
    localparam int P     = PINS_PER_PORT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_sel,
    input  reg_kind_e         kind,
    input  logic [WORD_W-1:0] wdata,
    input  logic [P-1:0]      din_sync,
    output logic [WORD_W-1:0] rd_word,
    output logic [P-1:0]      o_out,
    output logic [P-1:0]      o_oe,
    output logic [P-1:0]      o_ie,
    output logic [2*P-1:0]    o_pull,
    output logic [2*P-1:0]    o_drv,
    output logic [P-1:0]      o_slew,
    output logic [FUNC_W*P-1:0] o_func
);

    localparam logic [2*P-1:0] PULL_RST = {P{2'b01}};

    if (IS_DED) begin : g_ded
        logic [2*P-1:0] drv_q;
        logic [P-1:0]   slew_q;
        logic           unused_din;

        assign unused_din = ^din_sync;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                drv_q  <= '0;
                slew_q <= '0;
            end else if (wr_sel) begin
                unique case (kind)
                    RK_DRV:  drv_q  <= wdata;
                    RK_SLEW: slew_q <= mask_merge(slew_q, wdata);
                    default: ;
                endcase
            end
        end

        always_comb begin
            rd_word = '0;
            unique case (kind)
                RK_DRV:  rd_word = drv_q;
                RK_SLEW: rd_word = {{(WORD_W-P){1'b0}}, slew_q};
                default: rd_word = '0;
            endcase
        end

        assign o_out  = '0;
        assign o_oe   = '0;
        assign o_ie   = '0;
        assign o_pull = PULL_RST;
        assign o_drv  = drv_q;
        assign o_slew = slew_q;
        assign o_func = '0;

        p_ded_slew_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_sel && kind == RK_SLEW) |=>
                (((slew_q ^ $past(slew_q)) & ~$past(wdata[WORD_W-1:P])) == '0));

        p_ded_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_sel |=> ($stable(drv_q) && $stable(slew_q)));

    end else begin : g_gpio
        logic [P-1:0]        do_q;
        logic [P-1:0]        oe_q;
        logic [P-1:0]        ie_q;
        logic [P-1:0]        slew_q;
        logic [2*P-1:0]      pull_q;
        logic [2*P-1:0]      drv_q;
        logic [FUNC_W*P-1:0] fn_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                do_q   <= '0;
                oe_q   <= '0;
                ie_q   <= '0;
                slew_q <= '0;
                pull_q <= PULL_RST;
                drv_q  <= '0;
                fn_q   <= '0;
            end else if (wr_sel) begin
                unique case (kind)
                    RK_DOUT: do_q   <= mask_merge(do_q, wdata);
                    RK_OEN:  oe_q   <= mask_merge(oe_q, wdata);
                    RK_IEN:  ie_q   <= mask_merge(ie_q, wdata);
                    RK_SLEW: slew_q <= mask_merge(slew_q, wdata);
                    RK_PULL: pull_q <= wdata;
                    RK_DRV:  drv_q  <= wdata;
                    RK_FLO: begin
                        for (int k = 0; k < FUNC_PER_WORD; k++)
                            fn_q[k*FUNC_W +: FUNC_W] <= wdata[k*FUNC_SLOT +: FUNC_W];
                    end
                    RK_FHI: begin
                        for (int k = 0; k < FUNC_PER_WORD; k++)
                            fn_q[(k+FUNC_PER_WORD)*FUNC_W +: FUNC_W] <=
                                wdata[k*FUNC_SLOT +: FUNC_W];
                    end
                    default: ;
                endcase
            end
        end

        always_comb begin
            rd_word = '0;
            unique case (kind)
                RK_DOUT: rd_word = {{(WORD_W-P){1'b0}}, do_q};
                RK_OEN:  rd_word = {{(WORD_W-P){1'b0}}, oe_q};
                RK_IEN:  rd_word = {{(WORD_W-P){1'b0}}, ie_q};
                RK_SLEW: rd_word = {{(WORD_W-P){1'b0}}, slew_q};
                RK_DIN:  rd_word = {{(WORD_W-P){1'b0}}, din_sync};
                RK_PULL: rd_word = pull_q;
                RK_DRV:  rd_word = drv_q;
                RK_FLO: begin
                    for (int k = 0; k < FUNC_PER_WORD; k++)
                        rd_word[k*FUNC_SLOT +: FUNC_W] = fn_q[k*FUNC_W +: FUNC_W];
                end
                RK_FHI: begin
                    for (int k = 0; k < FUNC_PER_WORD; k++)
                        rd_word[k*FUNC_SLOT +: FUNC_W] =
                            fn_q[(k+FUNC_PER_WORD)*FUNC_W +: FUNC_W];
                end
                default: rd_word = '0;
            endcase
        end

        assign o_out  = do_q;
        assign o_oe   = oe_q;
        assign o_ie   = ie_q;
        assign o_pull = pull_q;
        assign o_drv  = drv_q;
        assign o_slew = slew_q;
        assign o_func = fn_q;

        p_mask_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_sel && kind == RK_DOUT) |=>
                (((do_q ^ $past(do_q)) & ~$past(wdata[WORD_W-1:P])) == '0));

        p_pull_replace_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_sel && kind == RK_PULL) |=> (pull_q == $past(wdata)));

        p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_sel |=> ($stable(do_q) && $stable(oe_q) && $stable(pull_q) &&
                         $stable(drv_q) && $stable(fn_q)));
    end

endmodule

// File: rtl/pb_bank.sv
module pb_bank
    import pb_pkg::*;
#(
    parameter int NUM_PORTS = 23,
    parameter int DED_PORT  = 22,
    parameter int ADDR_W    = 12,
    localparam int NPIN     = NUM_PORTS * PINS_PER_PORT
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_wr,
    input  logic [WORD_W-1:0]     bus_wdata,
    output logic [WORD_W-1:0]     bus_rdata,
    input  logic [NPIN-1:0]       pad_in,
    output logic [NPIN-1:0]       pad_out,
    output logic [NPIN-1:0]       pad_oe,
    output logic [NPIN-1:0]       pad_ie,
    output logic [2*NPIN-1:0]     pad_pull,
    output logic [2*NPIN-1:0]     pad_drv,
    output logic [NPIN-1:0]       pad_slew,
    output logic [FUNC_W*NPIN-1:0] pad_func
);

    localparam int PIDX_W = ADDR_W - WIN_SHIFT;
    localparam int P      = PINS_PER_PORT;

    logic [PIDX_W-1:0] dec_port;
    reg_kind_e         dec_kind;
    logic              dec_hit;
    logic [NPIN-1:0]   din_sync;
    logic [WORD_W-1:0] rd_words [NUM_PORTS];
    logic [WORD_W-1:0] rd_mux;
    logic [WORD_W-1:0] rd_q;

    pb_decode #(
        .NUM_PORTS (NUM_PORTS),
        .DED_PORT  (DED_PORT),
        .ADDR_W    (ADDR_W)
    ) u_decode (
        .addr     (bus_addr),
        .port_idx (dec_port),
        .kind     (dec_kind),
        .hit      (dec_hit)
    );

    pb_sync #(.W(NPIN)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (din_sync)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic wr_sel;
        assign wr_sel = bus_wr && dec_hit && (dec_port == PIDX_W'(p));

        pb_port #(.IS_DED(p == DED_PORT)) u_port (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_sel   (wr_sel),
            .kind     (dec_kind),
            .wdata    (bus_wdata),
            .din_sync (din_sync[p*P +: P]),
            .rd_word  (rd_words[p]),
            .o_out    (pad_out[p*P +: P]),
            .o_oe     (pad_oe[p*P +: P]),
            .o_ie     (pad_ie[p*P +: P]),
            .o_pull   (pad_pull[2*p*P +: 2*P]),
            .o_drv    (pad_drv[2*p*P +: 2*P]),
            .o_slew   (pad_slew[p*P +: P]),
            .o_func   (pad_func[FUNC_W*p*P +: FUNC_W*P])
        );
    end

    always_comb begin
        rd_mux = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (dec_hit && dec_port == PIDX_W'(p))
                rd_mux = rd_words[p];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_mux;
    end

    assign bus_rdata = rd_q;

    logic masked_now;
    assign masked_now = dec_hit && is_masked(dec_kind);

    p_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(masked_now) |-> (bus_rdata[WORD_W-1:P] == '0));

    p_miss_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!dec_hit) |-> (bus_rdata == '0));

endmodule

// File: tb/pb_bank_bench.sv
module pb_bank_bench;

    localparam int NP   = 23;
    localparam int NPIN = NP * 16;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [11:0]        bus_addr = '0;
    logic               bus_wr = 1'b0;
    logic [31:0]        bus_wdata = '0;
    logic [31:0]        bus_rdata;
    logic [NPIN-1:0]    pad_in = '0;
    logic [NPIN-1:0]    pad_out, pad_oe, pad_ie, pad_slew;
    logic [2*NPIN-1:0]  pad_pull, pad_drv;
    logic [3*NPIN-1:0]  pad_func;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pb_bank u_pb_bank (
        .clk (clk), .rst_n (rst_n),
        .bus_addr (bus_addr), .bus_wr (bus_wr),
        .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .pad_in (pad_in), .pad_out (pad_out), .pad_oe (pad_oe),
        .pad_ie (pad_ie), .pad_pull (pad_pull), .pad_drv (pad_drv),
        .pad_slew (pad_slew), .pad_func (pad_func)
    );

    // Scoreboard: expected read words queued by the driver.
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        pend = 1'b0;
    logic        due  = 1'b0;

    always @(posedge clk) due <= pend;

    always @(negedge clk) begin
        if (due && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (bus_rdata !== e) begin
                failures++;
                $display("FAIL %s read actual=%h expected=%h", t, bus_rdata, e);
            end
        end
    end

    task automatic chk(input string t, input logic [31:0] act, input logic [31:0] e);
        checks++;
        if (act !== e) begin
            failures++;
            $display("FAIL %s pad actual=%h expected=%h", t, act, e);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        bus_addr = a;
        bus_wr   = 1'b0;
        exp_q.push_back(e);
        tag_q.push_back(t);
        pend = 1'b1;
        @(posedge clk);
        #1 pend = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(12'h000, 32'h0, "R1 dout");
        rd(12'h004, 32'h0, "R1 oen");
        rd(12'h024, 32'h5555_5555, "R1 pull");
        rd(12'h028, 32'h0, "R1 drv");
        rd(12'h010, 32'h0, "R1 func");
        chk("R1 pad_pull pin0", {30'h0, pad_pull[1:0]}, 32'h1);
        chk("R1 pad_oe port0", {16'h0, pad_oe[15:0]}, 32'h0);

        // R2 masked writes
        wr(12'h000, 32'hFFFF_00A5);
        rd(12'h000, 32'h0000_00A5, "R2 full mask");
        wr(12'h000, 32'h0003_0000);
        rd(12'h000, 32'h0000_00A4, "R2 partial clear");
        wr(12'h000, 32'h8000_FFFF);
        rd(12'h000, 32'h0000_80A4, "R2 single pin");

        // R3 upper half zero, R10 pad update
        wr(12'h004, 32'hFFFF_1234);
        chk("R10 pad_oe port0", {16'h0, pad_oe[15:0]}, 32'h1234);
        rd(12'h004, 32'h0000_1234, "R3 oen upper zero");
        wr(12'h0EC, 32'h00F0_00FF);
        chk("R10 pad_slew port3", {16'h0, pad_slew[48 +: 16]}, 32'h00F0);
        rd(12'h0EC, 32'h0000_00F0, "R2 slew mask");

        // R4 pull / drive full replace
        wr(12'h064, 32'h0000_0002);
        rd(12'h064, 32'h0000_0002, "R4 pull replace");
        chk("R4 pull-up code pin16", {30'h0, pad_pull[32 +: 2]}, 32'h2);
        chk("R4 pull-down code pin17", {30'h0, pad_pull[34 +: 2]}, 32'h0);
        wr(12'h068, 32'hC000_0003);
        rd(12'h068, 32'hC000_0003, "R4 drv replace");
        chk("R4 drv pin31", {30'h0, pad_drv[62 +: 2]}, 32'h3);

        // R5 function select
        wr(12'h090, 32'hFFFF_FFFF);
        rd(12'h090, 32'h7777_7777, "R5 func lo reserved");
        chk("R5 pad_func pin39", {29'h0, pad_func[39*3 +: 3]}, 32'h7);
        wr(12'h094, 32'h0000_0005);
        rd(12'h094, 32'h0000_0005, "R5 func hi");
        chk("R5 pad_func pin40", {29'h0, pad_func[40*3 +: 3]}, 32'h5);
        chk("R5 pad_func pin41", {29'h0, pad_func[41*3 +: 3]}, 32'h0);

        // R6 input synchronizer
        @(negedge clk);
        pad_in[64 +: 16] = 16'h5A5A;
        repeat (3) @(posedge clk);
        rd(12'h120, 32'h0000_5A5A, "R6 din settled");
        @(negedge clk);
        pad_in[64 +: 16] = 16'h0001;
        rd(12'h120, 32'h0000_5A5A, "R6 din stale one edge");
        rd(12'h120, 32'h0000_0001, "R6 din after two edges");
        wr(12'h120, 32'hFFFF_FFFF);
        rd(12'h120, 32'h0000_0001, "R6 din write ignored");

        // R7 port isolation
        rd(12'h040, 32'h0, "R7 port1 dout untouched");
        wr(12'h140, 32'hFFFF_0F0F);
        rd(12'h140, 32'h0000_0F0F, "R7 port5 dout");
        rd(12'h000, 32'h0000_80A4, "R7 port0 dout kept");

        // R8 dedicated port
        wr(12'h590, 32'hFFFF_FFFF);
        rd(12'h590, 32'hFFFF_FFFF, "R8 ded drv");
        chk("R8 ded pad_drv", {30'h0, pad_drv[704 +: 2]}, 32'h3);
        wr(12'h594, 32'h0001_0001);
        rd(12'h594, 32'h0000_0001, "R8 ded slew");
        chk("R8 ded pad_slew", {31'h0, pad_slew[352]}, 32'h1);
        wr(12'h5A8, 32'h1234_5678);
        rd(12'h5A8, 32'h0, "R8 ded regular drv offset");
        rd(12'h590, 32'hFFFF_FFFF, "R8 ded drv kept");
        wr(12'h580, 32'hFFFF_FFFF);
        chk("R8 ded pad_out idle", {16'h0, pad_out[352 +: 16]}, 32'h0);
        rd(12'h580, 32'h0, "R8 ded dout unmapped");

        // R9 unmapped
        wr(12'h00C, 32'hFFFF_FFFF);
        rd(12'h00C, 32'h0, "R9 hole 0x0C");
        rd(12'h030, 32'h0, "R9 hole 0x30");
        wr(12'h5C0, 32'hFFFF_FFFF);
        rd(12'h5C0, 32'h0, "R9 port beyond range");
        rd(12'h000, 32'h0000_80A4, "R9 port0 unchanged");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++;
            failures++;
            $display("FAIL scoreboard residue actual=%0d expected=0", exp_q.size());
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule